// File: doc/BRIEF.md
# Immediate-Offset Word Load Address Unit

This unit sits between instruction issue and the data memory port for a 4-byte load whose offset is an immediate. On an accepted request it does three things. It decodes the immediate from one of four field formats and adds the immediate to, or subtracts it from, the base register value. It then presents either that offset address or the unmodified base to memory, for offset, pre-indexed or post-indexed addressing.

When the memory word comes back, the unit produces the register-file updates in the same cycle. These are the base writeback, the destination write, or a branch request when the destination is the program counter. The unit also raises flags for the combinations whose result cannot be relied on.

A request is taken only while the unit is idle and only when its condition passed. The read strobe follows one cycle after acceptance. The unit then waits for the memory-valid input and, in that cycle, emits all updates as single-cycle pulses.

Top module: `ldimm_agu`

## Requirements
- R1: The offset address is base + imm when `add_sel` is 1 and base − imm when it is 0, modulo 2^32.
- R2: `mem_addr` equals the offset address when `pre_idx` is 1 and the unmodified base value when `pre_idx` is 0.
- R3: In the completion cycle (`mem_valid` high while busy after the strobe), `base_we` equals the request's `wback` and `base_wdata` equals the offset address.
- R4: A request with `cond_ok` = 0 is dropped: no read strobe, `busy` stays 0, and no `base_we`, `rt_we` or `br_req` pulse follows.
- R5: The immediate comes from `imm_field` according to `imm_fmt`. Format 0 is bits [4:0] times 4, format 1 is bits [7:0] times 4, format 2 is bits [11:0] unscaled, and format 3 is bits [7:0] unscaled. All are zero-extended.
- R6: An immediate of zero gives the same address whether `add_sel` is 0 or 1.
- R7: `rd_stb` is high for exactly one cycle, the cycle after acceptance. `busy` stays high from then until the completion cycle, inclusive.
- R8: When `rt_idx` is 15 and `mem_addr[1:0]` is 00, completion raises `br_req` with `br_target` equal to the loaded word with bit 0 cleared. `br_mode` equals loaded bit 0, and `rt_we` stays 0.
- R9: When `rt_idx` is 15 and `mem_addr[1:0]` is not 00, completion raises `unpred` and neither `br_req` nor `rt_we`.
- R10: For `rt_idx` other than 15, completion raises `rt_we` with `rt_wdata` equal to the loaded word. `unknown` is raised exactly when `mem_addr[1:0]` is not 00 and `ua_en` was 0 at acceptance.
- R11: Completion raises `unpred` when `wback` is 1 and `rn_idx` equals `rt_idx`.
- R12: While `busy` is high, `issue` is ignored: `mem_addr` keeps the accepted request's address and no second strobe occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue | input | 1 | Request valid |
| cond_ok | input | 1 | Condition passed for this request |
| base_val | input | 32 | Base register value |
| imm_fmt | input | 2 | Immediate field format select |
| imm_field | input | 12 | Raw immediate field |
| add_sel | input | 1 | 1 adds the immediate, 0 subtracts it |
| pre_idx | input | 1 | 1 uses the offset address for the access |
| wback | input | 1 | Write the offset address back to the base |
| rn_idx | input | 4 | Base register number |
| rt_idx | input | 4 | Destination register number |
| ua_en | input | 1 | Unaligned word loads permitted |
| mem_rdata | input | 32 | Word returned by memory |
| mem_valid | input | 1 | Memory data valid |
| busy | output | 1 | Request in flight |
| rd_stb | output | 1 | Memory read strobe |
| mem_addr | output | 32 | Access address |
| base_we | output | 1 | Base writeback enable |
| base_wdata | output | 32 | Base writeback value |
| rt_we | output | 1 | Destination write enable |
| rt_wdata | output | 32 | Destination write data |
| br_req | output | 1 | Branch to loaded value |
| br_target | output | 32 | Branch target, bit 0 cleared |
| br_mode | output | 1 | Loaded bit 0 (instruction set select) |
| unpred | output | 1 | Result unpredictable |
| unknown | output | 1 | Destination value unknown |

## Verification
The bench builds the unit with its default 32-bit datapath, 4-bit register numbers and program counter at register 15. This keeps the wraparound of add and subtract near zero and near 2^32 within reach of a short list of base values. The bench sweeps every immediate format against bases with each low-bit pattern, both offset directions and all three addressing modes. It covers both the program counter and a general register as destination, with and without unaligned support, and with the base equal to and different from the destination. Together these reach every alignment, branch and flag outcome.

// File: rtl/ldimm_agu.sv
module ldimm_agu #(
  parameter int XLEN  = 32,
  parameter int RIDX  = 4,
  parameter int PCNUM = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue,
  input  logic            cond_ok,
  input  logic [XLEN-1:0] base_val,
  input  logic [1:0]      imm_fmt,
  input  logic [11:0]     imm_field,
  input  logic            add_sel,
  input  logic            pre_idx,
  input  logic            wback,
  input  logic [RIDX-1:0] rn_idx,
  input  logic [RIDX-1:0] rt_idx,
  input  logic            ua_en,
  input  logic [XLEN-1:0] mem_rdata,
  input  logic            mem_valid,
  output logic            busy,
  output logic            rd_stb,
  output logic [XLEN-1:0] mem_addr,
  output logic            base_we,
  output logic [XLEN-1:0] base_wdata,
  output logic            rt_we,
  output logic [XLEN-1:0] rt_wdata,
  output logic            br_req,
  output logic [XLEN-1:0] br_target,
  output logic            br_mode,
  output logic            unpred,
  output logic            unknown
);
  localparam logic [RIDX-1:0] PC_SEL = RIDX'(PCNUM);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;
  st_t st;

  logic [XLEN-1:0] imm_ext, off_c;
  logic [XLEN-1:0] r_addr, r_off;
  logic [RIDX-1:0] r_rt;
  logic            r_wb, r_clash, r_ua;
  logic            accept, done, to_pc, mis;

  always_comb begin
    case (imm_fmt)
      2'd0:    imm_ext = XLEN'({imm_field[4:0], 2'b00});
      2'd1:    imm_ext = XLEN'({imm_field[7:0], 2'b00});
      2'd2:    imm_ext = XLEN'(imm_field);
      default: imm_ext = XLEN'(imm_field[7:0]);
    endcase
  end

  assign off_c  = add_sel ? base_val + imm_ext : base_val - imm_ext;
  assign accept = (st == S_IDLE) && issue && cond_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      r_addr  <= '0;
      r_off   <= '0;
      r_rt    <= '0;
      r_wb    <= 1'b0;
      r_clash <= 1'b0;
      r_ua    <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          st      <= S_REQ;
          r_addr  <= pre_idx ? off_c : base_val;
          r_off   <= off_c;
          r_rt    <= rt_idx;
          r_wb    <= wback;
          r_clash <= wback && (rn_idx == rt_idx);
          r_ua    <= ua_en;
        end
        S_REQ:   st <= S_WAIT;
        default: if (mem_valid) st <= S_IDLE;
      endcase
    end
  end

  assign done  = (st == S_WAIT) && mem_valid;
  assign to_pc = (r_rt == PC_SEL);
  assign mis   = |r_addr[1:0];

  assign busy       = (st != S_IDLE);
  assign rd_stb     = (st == S_REQ);
  assign mem_addr   = r_addr;
  assign base_we    = done && r_wb;
  assign base_wdata = r_off;
  assign rt_we      = done && !to_pc;
  assign rt_wdata   = mem_rdata;
  assign br_req     = done && to_pc && !mis;
  assign br_target  = {mem_rdata[XLEN-1:1], 1'b0};
  assign br_mode    = mem_rdata[0];
  assign unpred     = done && ((to_pc && mis) || r_clash);
  assign unknown    = rt_we && mis && !r_ua;

  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> (!rd_stb && busy));
  // R4
  cond_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && issue && !cond_ok) |=> !rd_stb);
  // R12
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mem_addr));
  // R8
  branch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_req |-> (!rt_we && mem_addr[1:0] == 2'b00 && br_target[0] == 1'b0));
  // R10
  unknown_mis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unknown |-> (rt_we && mem_addr[1:0] != 2'b00));
  // R3
  wb_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (base_we || rt_we || br_req) |-> (busy && !rd_stb));
endmodule

// File: tb/ldimm_agu_bench.sv
module ldimm_agu_bench;
  logic clk = 0, rst_n = 0;
  logic issue = 0, cond_ok = 0, add_sel = 0, pre_idx = 0, wback = 0, ua_en = 0, mem_valid = 0;
  logic [31:0] base_val = 0, mem_rdata = 0;
  logic [1:0]  imm_fmt = 0;
  logic [11:0] imm_field = 0;
  logic [3:0]  rn_idx = 0, rt_idx = 0;
  logic busy, rd_stb, base_we, rt_we, br_req, br_mode, unpred, unknown;
  logic [31:0] mem_addr, base_wdata, rt_wdata, br_target;

  int total = 0, bad = 0, cyc = 0;

  always #5 clk = ~clk;

  ldimm_agu u_ldimm_agu (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: act=%0d exp<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] imm_of(input logic [1:0] f, input logic [11:0] v);
    case (f)
      2'd0: return 32'(v % 32) * 4;
      2'd1: return 32'(v % 256) * 4;
      2'd2: return 32'(v);
      default: return 32'(v % 256);
    endcase
  endfunction

  task automatic run_op(input logic [31:0] b, input logic [1:0] f, input logic [11:0] fld,
                        input bit ad, input bit ix, input bit wb, input logic [3:0] rn,
                        input logic [3:0] rt, input bit ua, input logic [31:0] dat);
    logic [31:0] imm, off, adr;
    bit mis, pc;
    imm = imm_of(f, fld);
    off = ad ? b + imm : b - imm;
    adr = ix ? off : b;
    mis = adr[1:0] != 2'b00;
    pc  = rt == 4'd15;
    @(negedge clk);
    issue = 1; cond_ok = 1; base_val = b; imm_fmt = f; imm_field = fld;
    add_sel = ad; pre_idx = ix; wback = wb; rn_idx = rn; rt_idx = rt; ua_en = ua;
    @(negedge clk);
    issue = 0;
    chk(rd_stb == 1, "R7 strobe", 32'(rd_stb), 1);
    chk(mem_addr == adr, "R1 R2 R5 address", mem_addr, adr);
    @(negedge clk);
    chk(rd_stb == 0 && busy == 1, "R7 strobe drop", {30'd0, busy, rd_stb}, 32'd2);
    chk(base_we == 0 && rt_we == 0 && br_req == 0, "R7 no early update",
        {29'd0, base_we, rt_we, br_req}, 0);
    mem_rdata = dat; mem_valid = 1;
    #1;
    chk(base_we == wb, "R3 wb enable", 32'(base_we), 32'(wb));
    if (wb) chk(base_wdata == off, "R3 wb value", base_wdata, off);
    if (pc) begin
      chk(br_req == !mis, "R8 R9 branch", 32'(br_req), 32'(!mis));
      chk(rt_we == 0, "R8 R9 no rt write", 32'(rt_we), 0);
      if (!mis) begin
        chk(br_target == {dat[31:1], 1'b0}, "R8 target", br_target, {dat[31:1], 1'b0});
        chk(br_mode == dat[0], "R8 mode", 32'(br_mode), 32'(dat[0]));
      end
    end else begin
      chk(rt_we == 1 && br_req == 0, "R10 rt write", {30'd0, rt_we, br_req}, 32'd2);
      chk(rt_wdata == dat, "R10 rt data", rt_wdata, dat);
      chk(unknown == (mis && !ua), "R10 unknown", 32'(unknown), 32'(mis && !ua));
    end
    chk(unpred == ((pc && mis) || (wb && rn == rt)), "R9 R11 unpred",
        32'(unpred), 32'((pc && mis) || (wb && rn == rt)));
    @(negedge clk);
    mem_valid = 0;
    chk(busy == 0, "R7 idle after", 32'(busy), 0);
  endtask

  initial begin
    logic [31:0] bases [4] = '{32'h0000_1000, 32'h0000_0003, 32'hFFFF_FFFE, 32'h7FFF_FFF1};
    logic [11:0] flds [3] = '{12'h000, 12'h0A5, 12'hFFF};
    int modes_ix [3] = '{1, 1, 0};
    int modes_wb [3] = '{0, 1, 1};
    int n = 0;
    repeat (3) @(negedge clk);
    // reset state
    chk(busy == 0 && rd_stb == 0, "R7 reset idle", {30'd0, busy, rd_stb}, 0);
    chk(base_we == 0 && rt_we == 0 && br_req == 0, "R3 reset quiet",
        {29'd0, base_we, rt_we, br_req}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int bi = 0; bi < 4; bi++)
      for (int f = 0; f < 4; f++)
        for (int fi = 0; fi < 3; fi++)
          for (int ad = 0; ad < 2; ad++)
            for (int m = 0; m < 3; m++)
              for (int ri = 0; ri < 2; ri++)
                for (int rni = 0; rni < 2; rni++)
                  for (int ua = 0; ua < 2; ua++) begin
                    n++;
                    run_op(bases[bi], 2'(f), flds[fi], ad[0], modes_ix[m][0], modes_wb[m][0],
                           rni ? 4'd3 : 4'd5, ri ? 4'd15 : 4'd3, ua[0],
                           32'hA5C3_0000 ^ bases[bi] ^ 32'(n));
                  end

    // R6: +0 and -0 give the same address
    for (int ad = 0; ad < 2; ad++) begin
      @(negedge clk);
      issue = 1; cond_ok = 1; base_val = 32'h0000_2468; imm_fmt = 2'd2; imm_field = 0;
      add_sel = ad[0]; pre_idx = 1; wback = 1; rn_idx = 1; rt_idx = 2; ua_en = 0;
      @(negedge clk);
      issue = 0;
      chk(mem_addr == 32'h0000_2468, "R6 zero offset", mem_addr, 32'h0000_2468);
      @(negedge clk);
      mem_valid = 1; #1;
      chk(base_wdata == 32'h0000_2468, "R6 zero wb", base_wdata, 32'h0000_2468);
      @(negedge clk); mem_valid = 0;
    end

    // R4: condition failed
    @(negedge clk);
    issue = 1; cond_ok = 0; base_val = 32'h100; rt_idx = 4; wback = 1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(rd_stb == 0 && busy == 0, "R4 dropped", {30'd0, busy, rd_stb}, 0);
      mem_valid = 1; #1;
      chk(base_we == 0 && rt_we == 0 && br_req == 0, "R4 no update",
          {29'd0, base_we, rt_we, br_req}, 0);
      mem_valid = 0;
    end
    issue = 0;

    // R12: issue held while busy
    @(negedge clk);
    issue = 1; cond_ok = 1; base_val = 32'h0000_4000; imm_fmt = 2'd3; imm_field = 12'h010;
    add_sel = 1; pre_idx = 1; wback = 0; rt_idx = 6; rn_idx = 7;
    @(negedge clk);
    base_val = 32'h0000_9000;
    chk(mem_addr == 32'h0000_4010, "R12 first addr", mem_addr, 32'h0000_4010);
    @(negedge clk);
    chk(mem_addr == 32'h0000_4010 && rd_stb == 0, "R12 addr held", mem_addr, 32'h0000_4010);
    issue = 0;
    mem_valid = 1;
    @(negedge clk);
    mem_valid = 0;
    chk(busy == 0 && rd_stb == 0, "R12 no second request", {30'd0, busy, rd_stb}, 0);
    @(negedge clk);
    chk(rd_stb == 0, "R12 no late strobe", 32'(rd_stb), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule